// File: doc/BRIEF.md
# Burst-Mode Loop Synchronization Controller

This block schedules ping-pong bursts on a single twisted pair. The two ends share the line by taking turns: the master sends, then the slave replies. The block also decides whether the loop is in sync. All timing advances on a symbol-rate enable, so one enabled cycle equals one symbol slot. A repeating period of `PERIOD_SYMS` slots carries one master burst and one slave reply. The defaults are 96 slots per 250 µs period, 37 symbols per burst (a start bit plus 36 data bits), a 6-symbol guard and a 4-symbol round trip.

At the master end, the period either free-runs or restarts on each rising edge of an external 4 kHz burst-sync input. The master transmits in the first slots of the period. It listens only after its burst, the guard and the round trip have passed. At the slave end, the period is anchored to the received start bit. After 36 further bits the slave closes its receiver, waits out the guard and then sends its reply.

A slave that is activated before it hears anything runs from its own timing and sends its reply in every other period only. This gives a 2 kHz wake-up signal. It stops doing so as soon as a start bit arrives. A flywheel counts consecutive good and empty receive windows to set and clear a sync status bit. While the block is powered down, a signal-detect status bit follows the line detector. Any change of either status bit raises a one-cycle interrupt request.

Top module: `bsc_loop_sync`

## Requirements
- R1: While reset is high, and in the cycle after it, all five outputs are 0.
- R2: While powered down (activate low), transmit and receive window stay low. `det_st` takes the value of `line_det` one enabled edge after it is sampled, and `irq` is 1 in exactly the cycle in which `det_st` changes. Once the block is active, `det_st` holds its value.
- R3: A master that has been activated for one enabled edge starts at slot 0. It drives `tx_burst` in slots 0 to 36 and `rx_window` in slots 47 to 95 of each 96-slot period, and the two are never high together.
- R4: In master mode, a rising edge of `burst_sync` sampled on an enabled edge makes the next slot slot 0 of a new period.
- R5: A slave activated without received timing starts at slot 0. It transmits in slots 42 to 78 of the first period and of every second period after it, and of no other period. Its receive window is low in slots 36 to 78 and high in all other slots.
- R6: A slave `rx_start` pulse that is sampled while `rx_window` is high makes the next slot slot 0. From then on, the slave transmits in slots 42 to 78 of every period.
- R7: An `rx_start` pulse that arrives while `rx_window` is low does not change the slot phase. A `burst_ok` pulse that arrives while `rx_window` is low does not count as a good burst.
- R8: Sync is evaluated at the last slot of each receive window: slot 95 for the master, slot 35 for the slave. The evaluation is good if `burst_ok` was seen inside the window. `sync_st` rises, with `irq` in the same cycle, right after the fourth consecutive good evaluation. A bad evaluation restarts the count.
- R9: In sync, four consecutive bad evaluations clear `sync_st` and raise `irq` in the same cycle, and the block searches again. A good evaluation restarts the miss count.
- R10: A low `activate` sampled on an enabled edge returns the block to power-down. `tx_burst`, `rx_window` and `sync_st` are then 0, and `irq` is raised if `sync_st` fell.
- R11: While `sym_en` is low, the slot position, the outputs and the status do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | Symbol-rate enable, one slot per enabled cycle |
| is_slave | input | 1 | 1 = slave end, 0 = master end |
| activate | input | 1 | 1 = powered up and running bursts |
| burst_sync | input | 1 | External 4 kHz burst alignment (master) |
| line_det | input | 1 | Line signal detector level |
| rx_start | input | 1 | Received start bit strobe |
| burst_ok | input | 1 | Decoder reports a correctly formatted burst |
| tx_burst | output | 1 | Transmit burst enable |
| rx_window | output | 1 | Receiver enable |
| sync_st | output | 1 | Loop sync status |
| det_st | output | 1 | Line signal detected status |
| irq | output | 1 | One-cycle pulse on any status change |

## Verification
- **Window outputs:** `tx_burst` and `rx_window` are decoded from registered slot state. They therefore take the new slot's value in the cycle that follows the enabled edge. The bench keeps its own slot index, advances it once per enabled edge, and compares both outputs in every cycle of whole periods in each mode.
- **Status after an evaluation:** the new sync status and its `irq` appear together right after the edge that ends the evaluation slot. The bench checks them when the period sweep returns.
- **Detect status:** `det_st` changes one edge after `line_det` is sampled, and the bench checks it there.
- **Stimulus placement:** realignments and stray strobes are placed at chosen slots, and the expected phase shift is applied on the next slot.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SEARCH,
        ST_ACQ,
        ST_SYNC
    } fly_state_e;

    typedef struct packed {
        logic sync;
        logic det;
    } status_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bsc_slot_timer.sv
module bsc_slot_timer #(
    parameter int PERIOD_SYMS = 96,
    parameter int SLOT_W      = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_en,
    input  logic              active,
    input  logic              is_slave,
    input  logic              burst_sync,
    input  logic              slave_align,
    output logic [SLOT_W-1:0] slot,
    output logic              turn
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PERIOD_SYMS - 1);

    logic sync_q;
    logic master_align;
    logic restart;

    assign master_align = !is_slave && burst_sync && !sync_q;
    assign restart      = slave_align || master_align || (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            turn   <= 1'b1;
            sync_q <= 1'b0;
        end else if (sym_en) begin
            sync_q <= burst_sync;
            if (!active) begin
                slot <= '0;
                turn <= 1'b1;
            end else if (restart) begin
                slot <= '0;
                turn <= ~turn;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsc_burst_window.sv
module bsc_burst_window
    import bsc_pkg::*;
#(
    parameter int PERIOD_SYMS = 96,
    parameter int BURST_SYMS  = 37,
    parameter int GUARD_SYMS  = 6,
    parameter int RTD_SYMS    = 4,
    parameter int SLOT_W      = 7
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              turn,
    input  logic              is_slave,
    input  fly_state_e        state,
    output logic              tx_burst,
    output logic              rx_win,
    output logic              win_end
);
    localparam int DATA_BITS = BURST_SYMS - 1;
    localparam logic [SLOT_W-1:0] M_TX_END  = SLOT_W'(BURST_SYMS);
    localparam logic [SLOT_W-1:0] M_OPEN    = SLOT_W'(BURST_SYMS + GUARD_SYMS + RTD_SYMS);
    localparam logic [SLOT_W-1:0] M_EVAL    = SLOT_W'(PERIOD_SYMS - 1);
    localparam logic [SLOT_W-1:0] S_CLOSE   = SLOT_W'(DATA_BITS);
    localparam logic [SLOT_W-1:0] S_TX_LO   = SLOT_W'(DATA_BITS + GUARD_SYMS);
    localparam logic [SLOT_W-1:0] S_TX_HI   = SLOT_W'(DATA_BITS + GUARD_SYMS + BURST_SYMS);
    localparam logic [SLOT_W-1:0] S_EVAL    = SLOT_W'(DATA_BITS - 1);

    logic active;
    logic s_tx_slot;
    logic s_quiet;

    assign active    = (state != ST_IDLE);
    assign s_tx_slot = (slot >= S_TX_LO) && (slot < S_TX_HI);
    assign s_quiet   = (slot >= S_CLOSE) && (slot < S_TX_HI);

    always_comb begin
        if (!active) begin
            tx_burst = 1'b0;
            rx_win   = 1'b0;
            win_end  = 1'b0;
        end else if (is_slave) begin
            tx_burst = s_tx_slot && ((state != ST_WAKE) || turn);
            rx_win   = !s_quiet;
            win_end  = (slot == S_EVAL);
        end else begin
            tx_burst = (slot < M_TX_END);
            rx_win   = (slot >= M_OPEN);
            win_end  = (slot == M_EVAL);
        end
    end
endmodule

// File: rtl/bsc_flywheel.sv
module bsc_flywheel
    import bsc_pkg::*;
#(
    parameter int ACQ_N  = 4,
    parameter int LOSS_N = 4,
    parameter int CNT_W  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_en,
    input  logic       activate,
    input  logic       is_slave,
    input  logic       line_det,
    input  logic       burst_ok,
    input  logic       rx_win,
    input  logic       win_end,
    input  logic       slave_align,
    output fly_state_e state,
    output logic       sync_st,
    output logic       det_st,
    output logic       irq
);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_N - 1);
    localparam logic [CNT_W-1:0] LOSS_LAST = CNT_W'(LOSS_N - 1);

    fly_state_e       st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             ok_seen;
    logic             good;
    status_t          stat_q, stat_n;
    logic             irq_q;

    assign good = ok_seen || (burst_ok && rx_win);

    always_comb begin
        st_n = state;
        cnt_n = cnt;
        if (!activate) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    st_n  = is_slave ? ST_WAKE : ST_SEARCH;
                    cnt_n = '0;
                end
                ST_WAKE: begin
                    if (slave_align) st_n = ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (win_end && good) begin
                        if (ACQ_LAST == '0) begin
                            st_n = ST_SYNC;
                            cnt_n = '0;
                        end else begin
                            st_n = ST_ACQ;
                            cnt_n = CNT_W'(1);
                        end
                    end
                end
                ST_ACQ: begin
                    if (win_end) begin
                        if (!good) begin
                            st_n  = ST_SEARCH;
                            cnt_n = '0;
                        end else if (cnt == ACQ_LAST) begin
                            st_n  = ST_SYNC;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (win_end) begin
                        if (good) begin
                            cnt_n = '0;
                        end else if (cnt == LOSS_LAST) begin
                            st_n  = ST_SEARCH;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
        stat_n.sync = (st_n == ST_SYNC);
        stat_n.det  = (state == ST_IDLE) ? line_det : stat_q.det;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            ok_seen <= 1'b0;
            stat_q  <= '0;
            irq_q   <= 1'b0;
        end else if (sym_en) begin
            state   <= st_n;
            cnt     <= cnt_n;
            if ((st_n == ST_IDLE) || win_end) ok_seen <= 1'b0;
            else if (burst_ok && rx_win)      ok_seen <= 1'b1;
            stat_q  <= stat_n;
            irq_q   <= (stat_n != stat_q);
        end else begin
            irq_q   <= 1'b0;
        end
    end

    assign sync_st = stat_q.sync;
    assign det_st  = stat_q.det;
    assign irq     = irq_q;
endmodule

// File: rtl/bsc_loop_sync.sv
module bsc_loop_sync
    import bsc_pkg::*;
#(
    parameter int PERIOD_SYMS = 96,
    parameter int BURST_SYMS  = 37,
    parameter int GUARD_SYMS  = 6,
    parameter int RTD_SYMS    = 4,
    parameter int ACQ_N       = 4,
    parameter int LOSS_N      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_en,
    input  logic is_slave,
    input  logic activate,
    input  logic burst_sync,
    input  logic line_det,
    input  logic rx_start,
    input  logic burst_ok,
    output logic tx_burst,
    output logic rx_window,
    output logic sync_st,
    output logic det_st,
    output logic irq
);
    localparam int SLOT_W = $clog2(PERIOD_SYMS);
    localparam int CNT_W  = $clog2(max_u(ACQ_N, LOSS_N) + 1);

    fly_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic              turn;
    logic              rx_win;
    logic              win_end;
    logic              slave_align;
    logic              active;

    assign active      = (state != ST_IDLE);
    assign slave_align = is_slave && rx_start && rx_win;

    bsc_slot_timer #(
        .PERIOD_SYMS(PERIOD_SYMS),
        .SLOT_W     (SLOT_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .sym_en     (sym_en),
        .active     (active),
        .is_slave   (is_slave),
        .burst_sync (burst_sync),
        .slave_align(slave_align),
        .slot       (slot),
        .turn       (turn)
    );

    bsc_burst_window #(
        .PERIOD_SYMS(PERIOD_SYMS),
        .BURST_SYMS (BURST_SYMS),
        .GUARD_SYMS (GUARD_SYMS),
        .RTD_SYMS   (RTD_SYMS),
        .SLOT_W     (SLOT_W)
    ) window_i (
        .slot    (slot),
        .turn    (turn),
        .is_slave(is_slave),
        .state   (state),
        .tx_burst(tx_burst),
        .rx_win  (rx_win),
        .win_end (win_end)
    );

    bsc_flywheel #(
        .ACQ_N (ACQ_N),
        .LOSS_N(LOSS_N),
        .CNT_W (CNT_W)
    ) fly_i (
        .clk        (clk),
        .rst        (rst),
        .sym_en     (sym_en),
        .activate   (activate),
        .is_slave   (is_slave),
        .line_det   (line_det),
        .burst_ok   (burst_ok),
        .rx_win     (rx_win),
        .win_end    (win_end),
        .slave_align(slave_align),
        .state      (state),
        .sync_st    (sync_st),
        .det_st     (det_st),
        .irq        (irq)
    );

    assign rx_window = rx_win;
endmodule

// File: rtl/bsc_loop_sync_chk.sv
module bsc_loop_sync_chk (
    input logic clk,
    input logic rst,
    input logic sym_en,
    input logic activate,
    input logic win_end,
    input logic tx_burst,
    input logic rx_window,
    input logic sync_st,
    input logic det_st,
    input logic irq
);
    AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_burst && rx_window)); // R3

    AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sym_en && !activate) |=> (!tx_burst && !rx_window && !sync_st)); // R10

    AST_IRQ_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_st) |-> irq); // R8

    AST_IRQ_ON_DET: assert property (@(posedge clk) disable iff (rst)
        !$stable(det_st) |-> irq); // R2

    AST_SYNC_AT_EVAL: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_st) |-> $past(win_end && sym_en)); // R8

    AST_LOSS_AT_EVAL: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_st) && $past(activate)) |-> $past(win_end && sym_en)); // R9

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !sym_en |=> ($stable(tx_burst) && $stable(rx_window) && $stable(sync_st))); // R11
endmodule

bind bsc_loop_sync bsc_loop_sync_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .sym_en   (sym_en),
    .activate (activate),
    .win_end  (win_end),
    .tx_burst (tx_burst),
    .rx_window(rx_window),
    .sync_st  (sync_st),
    .det_st   (det_st),
    .irq      (irq)
);

// File: tb/bsc_loop_sync_tb_top.sv
module bsc_loop_sync_tb_top;
    localparam int P = 96;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_en = 1'b1;
    logic is_slave = 1'b0;
    logic activate = 1'b0;
    logic burst_sync = 1'b0;
    logic line_det = 1'b0;
    logic rx_start = 1'b0;
    logic burst_ok = 1'b0;
    logic tx_burst, rx_window, sync_st, det_st, irq;

    int k = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bsc_loop_sync dut_i (
        .clk(clk), .rst(rst), .sym_en(sym_en), .is_slave(is_slave),
        .activate(activate), .burst_sync(burst_sync), .line_det(line_det),
        .rx_start(rx_start), .burst_ok(burst_ok), .tx_burst(tx_burst),
        .rx_window(rx_window), .sync_st(sync_st), .det_st(det_st), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s slot=%0d actual=%0d expected=%0d", tag, k, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            k = (k + 1) % P;
        end
    endtask

    task automatic m_period(input bit give_ok, input int ok_slot);
        for (int i = 0; i < P; i++) begin
            chk("R3 tx_burst", int'(tx_burst), int'(k < 37));
            chk("R3 rx_window", int'(rx_window), int'(k >= 47));
            if (k != 0) chk("R8 irq quiet", int'(irq), 0);
            burst_ok = give_ok && (k == ok_slot);
            step();
            burst_ok = 1'b0;
            k = (k + 1) % P;
        end
    endtask

    task automatic s_period(input bit exp_tx, input bit give_start, input int start_slot,
                            input bit give_ok, input int stray_slot, input string tag);
        bit fin;
        fin = 1'b0;
        while (!fin) begin
            chk({tag, " tx_burst"}, int'(tx_burst), int'(exp_tx && k >= 42 && k < 79));
            chk({tag, " rx_window"}, int'(rx_window), int'(!(k >= 36 && k < 79)));
            rx_start = (give_start && k == start_slot) || (k == stray_slot);
            burst_ok = give_ok && (k == 20);
            step();
            rx_start = 1'b0;
            burst_ok = 1'b0;
            if ((give_start && k == start_slot) || k == P - 1) begin
                k = 0;
                fin = 1'b1;
            end else begin
                k++;
            end
        end
    endtask

    initial begin
        @(negedge clk);
        step();
        step();
        // R1: reset state
        chk("R1 tx_burst", int'(tx_burst), 0);
        chk("R1 rx_window", int'(rx_window), 0);
        chk("R1 sync_st", int'(sync_st), 0);
        chk("R1 det_st", int'(det_st), 0);
        chk("R1 irq", int'(irq), 0);
        rst = 1'b0;
        step();
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 tx after reset", int'(tx_burst), 0);

        // R2: detection while powered down
        line_det = 1'b1;
        step();
        chk("R2 det_st", int'(det_st), 1);
        chk("R2 irq", int'(irq), 1);
        chk("R2 tx idle", int'(tx_burst), 0);
        chk("R2 rx idle", int'(rx_window), 0);
        step();
        chk("R2 irq pulse", int'(irq), 0);

        // Master activation
        activate = 1'b1;
        step();
        k = 0;
        chk("R3 first slot tx", int'(tx_burst), 1);
        for (int n = 0; n < 3; n++) m_period(1'b1, 60);
        chk("R8 three good", int'(sync_st), 0);
        m_period(1'b1, 10);
        chk("R7 ok outside window", int'(sync_st), 0);
        for (int n = 0; n < 3; n++) m_period(1'b1, 60);
        chk("R8 count restarted", int'(sync_st), 0);
        m_period(1'b1, 60);
        chk("R8 sync acquired", int'(sync_st), 1);
        chk("R8 irq on acquire", int'(irq), 1);

        // R9: loss of sync
        for (int n = 0; n < 3; n++) m_period(1'b0, 0);
        chk("R9 three missing", int'(sync_st), 1);
        m_period(1'b1, 50);
        for (int n = 0; n < 3; n++) m_period(1'b0, 0);
        chk("R9 miss count restarted", int'(sync_st), 1);
        m_period(1'b0, 0);
        chk("R9 sync lost", int'(sync_st), 0);
        chk("R9 irq on loss", int'(irq), 1);

        // R4: external burst alignment
        advance(20);
        burst_sync = 1'b1;
        step();
        k = 0;
        burst_sync = 1'b0;
        chk("R4 realigned tx", int'(tx_burst), 1);
        advance(16);
        chk("R4 tx beyond old phase", int'(tx_burst), 1);
        advance(21);
        chk("R4 tx ends at new slot 37", int'(tx_burst), 0);
        advance(P - 37);
        for (int n = 0; n < 4; n++) m_period(1'b1, 60);
        chk("R8 reacquired", int'(sync_st), 1);

        // R11: enable low freezes
        advance(36);
        sym_en = 1'b0;
        for (int n = 0; n < 5; n++) begin
            step();
            chk("R11 tx frozen", int'(tx_burst), 1);
            chk("R11 sync frozen", int'(sync_st), 1);
        end
        sym_en = 1'b1;
        step();
        k = 37;
        chk("R11 tx resumes", int'(tx_burst), 0);
        chk("R11 rx gap", int'(rx_window), 0);
        advance(P - 37);

        // R10: deactivate
        activate = 1'b0;
        step();
        chk("R10 tx off", int'(tx_burst), 0);
        chk("R10 rx off", int'(rx_window), 0);
        chk("R10 sync cleared", int'(sync_st), 0);
        chk("R10 irq", int'(irq), 1);
        chk("R2 det held", int'(det_st), 1);
        line_det = 1'b0;
        step();
        chk("R2 det follows", int'(det_st), 0);
        chk("R2 irq on clear", int'(irq), 1);

        // Slave end
        rst = 1'b1;
        step();
        rst = 1'b0;
        is_slave = 1'b1;
        activate = 1'b1;
        step();
        k = 0;
        s_period(1'b1, 1'b0, 0, 1'b0, -1, "R5");
        s_period(1'b0, 1'b0, 0, 1'b0, -1, "R5");
        s_period(1'b1, 1'b0, 0, 1'b0, -1, "R5");
        s_period(1'b0, 1'b1, 90, 1'b0, -1, "R5");
        for (int n = 0; n < 3; n++) s_period(1'b1, 1'b1, P - 1, 1'b1, -1, "R6");
        chk("R8 slave three good", int'(sync_st), 0);
        s_period(1'b1, 1'b1, P - 1, 1'b1, -1, "R6");
        chk("R8 slave sync", int'(sync_st), 1);
        s_period(1'b1, 1'b1, P - 1, 1'b1, 50, "R7");
        s_period(1'b1, 1'b1, 85, 1'b1, -1, "R6");
        s_period(1'b1, 1'b1, P - 1, 1'b1, -1, "R6");
        chk("R6 sync kept over realign", int'(sync_st), 1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule